// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block gathers the event sources of one general-purpose timer and reduces them to a single level-sensitive interrupt request. Three kinds of event are recorded as sticky flags: an update event, one capture/compare event per channel, and an edge on an external trigger line. The trigger line is asynchronous. It passes through a synchroniser before its edges are detected. In normal mode only a rising edge counts. In gated mode an edge in either direction counts.

Software reaches three registers through a small register bus. The first holds the flags and is cleared by writing ones. The second is an enable mask with the same bit layout. The third records missed events and is also cleared by writing ones. A capture/compare event that arrives while its channel's flag is still pending sets that channel's missed bit. When a channel works in capture mode, a read of its capture register is reported to this block by a per-channel strobe, and that strobe clears the channel's flag. The interrupt output is high whenever a flag and its mask bit are both set.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the flag, mask and missed registers all read zero and `irq` is low.
- R2: An `upd_evt` pulse sets flag bit 0 at the next clock edge.
- R3: A pulse on `cc_evt[k]` sets flag bit k+1 at the next clock edge (channel 1 at bit 1 through channel 4 at bit 4).
- R4: With `gated_mode` low, a rising edge of `ext_trig` sets flag bit 6, and the flag becomes visible three clock edges after the input changes. A falling edge has no effect.
- R5: With `gated_mode` high, a falling edge of `ext_trig` also sets flag bit 6, with the same three-edge latency.
- R6: A bus write to address 0 clears every flag bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R7: When a hardware event and a write-1-to-clear hit the same flag bit in one cycle, the flag ends up set.
- R8: A pulse on `cc_rd[k]` clears flag bit k+1 if `cc_capmode[k]` is high, and has no effect if it is low.
- R9: When a capture-mode read strobe and a new event on the same channel arrive in one cycle, the flag stays set and the missed bit is not set.
- R10: A `cc_evt[k]` pulse that arrives while flag bit k+1 is already set sets bit k+1 of the missed register (address 2, bits 1 to 4). Missed bits are never cleared except by a write.
- R11: A bus write to address 2 clears each missed bit whose data bit is 1. If a new missed event hits the same bit in that cycle, the missed bit stays set.
- R12: The mask register at address 1 is read/write on its implemented bits 0 to 4 and 6. `irq` is high exactly when some flag bit and its mask bit are both 1, and it follows the register state within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_trig | input | 1 | Asynchronous external trigger line |
| gated_mode | input | 1 | 1 = both trigger edges count, 0 = rising edge only |
| cc_evt | input | 4 | Per-channel capture/compare event strobes |
| cc_capmode | input | 4 | Per-channel capture-mode indicator |
| cc_rd | input | 4 | Per-channel capture-register read strobes |
| upd_evt | input | 1 | Update event strobe |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 flags, 1 mask, 2 missed |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Level interrupt request |

## Verification
A flag that is stuck or set in error appears on `bus_rdata` in the first read after the edge where it went wrong. If that bit is enabled in the mask, it also appears on `irq` in the same cycle. A fault in missed-event tracking stays hidden until address 2 is read, because missed bits do not drive `irq`. The bench therefore reads that register after every stimulus cycle. A fault in the trigger path shows only after the three-edge synchroniser delay, so those checks sample at each of the three edges.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

   // register addresses on the bus
   localparam int ADDR_FLAG = 0;
   localparam int ADDR_MASK = 1;
   localparam int ADDR_MISS = 2;

   // fixed bit of the update flag; channels start right above it
   localparam int UPD_POS  = 0;
   localparam int CH_BASE  = 1;

   // bits that hold a flag: update, channels, trigger
   function automatic logic [31:0] flag_bits(input int num_ch, input int trig_pos);
      logic [31:0] m;
      m = 32'd1 << UPD_POS;
      for (int i = 0; i < num_ch; i++) m[CH_BASE + i] = 1'b1;
      m[trig_pos] = 1'b1;
      return m;
   endfunction

   // bits that hold a missed indication: channels only
   function automatic logic [31:0] miss_bits(input int num_ch);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < num_ch; i++) m[CH_BASE + i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/tmr_irq_trig_sync.sv
module tmr_irq_trig_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic both_edges,
   output logic trig_evt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sync_out;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= trig_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_out;
   end

   always_comb begin
      if (both_edges) trig_evt = sync_out ^ prev_q;
      else            trig_evt = sync_out & ~prev_q;
   end

endmodule

// File: rtl/tmr_irq_sticky.sv
module tmr_irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   // set has priority over clear
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

endmodule

// File: rtl/tmr_irq_regif.sv
module tmr_irq_regif
   import tmr_irq_pkg::*;
#(
   parameter int                ADDR_W    = 2,
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] MASK_IMPL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] flag_q,
   input  logic [DATA_W-1:0] miss_q,
   output logic [DATA_W-1:0] flag_w1c,
   output logic [DATA_W-1:0] miss_w1c,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] bus_rdata
);

   logic hit_flag, hit_mask, hit_miss;
   logic do_wr;

   assign hit_flag = (bus_addr == ADDR_W'(ADDR_FLAG));
   assign hit_mask = (bus_addr == ADDR_W'(ADDR_MASK));
   assign hit_miss = (bus_addr == ADDR_W'(ADDR_MISS));
   assign do_wr    = bus_sel & bus_wr;

   assign flag_w1c = (do_wr && hit_flag) ? bus_wdata : '0;
   assign miss_w1c = (do_wr && hit_miss) ? bus_wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)                mask_q <= '0;
      else if (do_wr && hit_mask) mask_q <= bus_wdata & MASK_IMPL;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_flag)      bus_rdata = flag_q;
      else if (hit_mask) bus_rdata = mask_q;
      else if (hit_miss) bus_rdata = miss_q;
   end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
   import tmr_irq_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int TRIG_BIT    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_trig,
   input  logic              gated_mode,
   input  logic [NUM_CH-1:0] cc_evt,
   input  logic [NUM_CH-1:0] cc_capmode,
   input  logic [NUM_CH-1:0] cc_rd,
   input  logic              upd_evt,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam logic [DATA_W-1:0] FLAG_IMPL = DATA_W'(flag_bits(NUM_CH, TRIG_BIT));
   localparam logic [DATA_W-1:0] MISS_IMPL = DATA_W'(miss_bits(NUM_CH));

   generate
      if (NUM_CH < 1 || CH_BASE + NUM_CH > TRIG_BIT) begin : g_bad_ch
         $error("tmr_irq_ctrl: channel bits must lie below the trigger bit");
      end
      if (TRIG_BIT >= DATA_W) begin : g_bad_trig
         $error("tmr_irq_ctrl: trigger bit outside data width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("tmr_irq_ctrl: address needs at least 2 bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tmr_irq_ctrl: synchroniser needs at least 2 stages");
      end
   endgenerate

   logic [DATA_W-1:0] flag_q, miss_q, mask_q;
   logic [DATA_W-1:0] flag_w1c, miss_w1c;
   logic [DATA_W-1:0] flag_set, flag_clr, miss_set;
   logic [NUM_CH-1:0] rd_clr;
   logic              trig_evt;

   tmr_irq_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_in    (ext_trig),
      .both_edges (gated_mode),
      .trig_evt   (trig_evt)
   );

   assign rd_clr = cc_rd & cc_capmode;

   // set and clear sources per bit position
   always_comb begin
      flag_set = '0;
      flag_clr = flag_w1c;
      miss_set = '0;
      flag_set[UPD_POS]  = upd_evt;
      flag_set[TRIG_BIT] = trig_evt;
      for (int k = 0; k < NUM_CH; k++) begin
         flag_set[CH_BASE+k] = cc_evt[k];
         flag_clr[CH_BASE+k] = flag_w1c[CH_BASE+k] | rd_clr[k];
         miss_set[CH_BASE+k] = cc_evt[k] & flag_q[CH_BASE+k] & ~rd_clr[k];
      end
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (FLAG_IMPL[b]) begin : g_flag
            tmr_irq_sticky u_flag (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (flag_set[b]),
               .clr_i (flag_clr[b]),
               .q_o   (flag_q[b])
            );
         end else begin : g_noflag
            assign flag_q[b] = 1'b0;
         end
         if (MISS_IMPL[b]) begin : g_miss
            tmr_irq_sticky u_miss (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (miss_set[b]),
               .clr_i (miss_w1c[b]),
               .q_o   (miss_q[b])
            );
         end else begin : g_nomiss
            assign miss_q[b] = 1'b0;
         end
      end
   endgenerate

   tmr_irq_regif #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MASK_IMPL (FLAG_IMPL)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .flag_q    (flag_q),
      .miss_q    (miss_q),
      .flag_w1c  (flag_w1c),
      .miss_w1c  (miss_w1c),
      .mask_q    (mask_q),
      .bus_rdata (bus_rdata)
   );

   assign irq = |(flag_q & mask_q);

endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
   parameter int NUM_CH   = 4,
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 8,
   parameter int TRIG_BIT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] cc_evt,
   input logic [NUM_CH-1:0] cc_capmode,
   input logic [NUM_CH-1:0] cc_rd,
   input logic              upd_evt,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] flag_q,
   input logic [DATA_W-1:0] mask_q,
   input logic [DATA_W-1:0] miss_q,
   input logic              irq
);

   logic              wr_flag, wr_miss;
   logic [NUM_CH-1:0] rd_only, repeat_hit;

   assign wr_flag    = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
   assign wr_miss    = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
   assign rd_only    = cc_rd & cc_capmode & ~cc_evt;
   assign repeat_hit = cc_evt & flag_q[NUM_CH:1] & ~(cc_rd & cc_capmode);

   AST_UPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> flag_q[0]); // R2

   AST_CC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_evt != '0) |=> ((flag_q[NUM_CH:1] & $past(cc_evt)) == $past(cc_evt))); // R3

   AST_W1C_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && bus_wdata[0] && !upd_evt) |=> !flag_q[0]); // R6

   AST_CAP_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only != '0) |=> ((flag_q[NUM_CH:1] & $past(rd_only)) == '0)); // R8

   AST_MISS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (repeat_hit != '0) |=> ((miss_q[NUM_CH:1] & $past(repeat_hit)) == $past(repeat_hit))); // R10

   AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_miss |=> ((miss_q & $past(miss_q)) == $past(miss_q))); // R11

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R12

   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_q != '0)); // R12

   AST_TRIG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[TRIG_BIT] && !wr_flag) |=> flag_q[TRIG_BIT]); // R4

endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(
   .NUM_CH   (NUM_CH),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .TRIG_BIT (TRIG_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cc_evt     (cc_evt),
   .cc_capmode (cc_capmode),
   .cc_rd      (cc_rd),
   .upd_evt    (upd_evt),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .flag_q     (flag_q),
   .mask_q     (mask_q),
   .miss_q     (miss_q),
   .irq        (irq)
);

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_trig = 1'b0;
   logic       gated_mode = 1'b0;
   logic [3:0] cc_evt = '0;
   logic [3:0] cc_capmode = '0;
   logic [3:0] cc_rd = '0;
   logic       upd_evt = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   tmr_irq_ctrl u_tmr_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .gated_mode(gated_mode),
      .cc_evt(cc_evt), .cc_capmode(cc_capmode), .cc_rd(cc_rd), .upd_evt(upd_evt),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct packed {
      logic       upd;
      logic [3:0] ev;
      logic [3:0] cap;
      logic [3:0] rd;
      logic       wr;
      logic [1:0] ad;
      logic [7:0] wd;
      logic [7:0] exp_flag;
      logic [7:0] exp_miss;
   } vec_t;

   localparam int NVEC = 15;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 4'h0, 4'h0, 4'h0, 1'b0, 2'd0, 8'h00, 8'h01, 8'h00}, // R2 update
      '{1'b0, 4'h1, 4'h0, 4'h0, 1'b0, 2'd0, 8'h00, 8'h03, 8'h00}, // R3 ch1
      '{1'b0, 4'h8, 4'h0, 4'h0, 1'b0, 2'd0, 8'h00, 8'h13, 8'h00}, // R3 ch4
      '{1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 2'd0, 8'h01, 8'h12, 8'h00}, // R6 clear upd
      '{1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 2'd0, 8'h00, 8'h12, 8'h00}, // R6 zero no effect
      '{1'b0, 4'h1, 4'h0, 4'h0, 1'b0, 2'd0, 8'h00, 8'h12, 8'h02}, // R10 ch1 repeat
      '{1'b0, 4'h2, 4'h0, 4'h0, 1'b1, 2'd0, 8'h04, 8'h16, 8'h02}, // R7 event beats clear
      '{1'b0, 4'h0, 4'h1, 4'h1, 1'b0, 2'd0, 8'h00, 8'h14, 8'h02}, // R8 capture read clears
      '{1'b0, 4'h0, 4'h0, 4'h8, 1'b0, 2'd0, 8'h00, 8'h14, 8'h02}, // R8 compare read ignored
      '{1'b0, 4'h4, 4'h0, 4'h0, 1'b0, 2'd0, 8'h00, 8'h1C, 8'h02}, // R3 ch3
      '{1'b0, 4'h4, 4'h4, 4'h4, 1'b0, 2'd0, 8'h00, 8'h1C, 8'h02}, // R9 read + event
      '{1'b0, 4'h4, 4'h0, 4'h0, 1'b0, 2'd0, 8'h00, 8'h1C, 8'h0A}, // R10 ch3 repeat
      '{1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 2'd2, 8'h02, 8'h1C, 8'h08}, // R11 clear missed ch1
      '{1'b0, 4'h4, 4'h0, 4'h0, 1'b1, 2'd2, 8'h08, 8'h1C, 8'h08}, // R11 missed set wins
      '{1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 2'd0, 8'hFF, 8'h00, 8'h08}  // R6 clear all
   };

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      upd_evt = 1'b0; cc_evt = '0; cc_capmode = '0; cc_rd = '0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      idle_inputs();
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
      idle_inputs();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_reg(2'd0, d); check("R1", "flags after reset", d, 8'h00);
      read_reg(2'd1, d); check("R1", "mask after reset", d, 8'h00);
      read_reg(2'd2, d); check("R1", "missed after reset", d, 8'h00);
      check("R1", "irq after reset", {7'b0, irq}, 8'h00);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         upd_evt = VECS[i].upd; cc_evt = VECS[i].ev; cc_capmode = VECS[i].cap;
         cc_rd = VECS[i].rd; bus_sel = VECS[i].wr; bus_wr = VECS[i].wr;
         bus_addr = VECS[i].ad; bus_wdata = VECS[i].wd;
         step();
         read_reg(2'd0, d); check($sformatf("vector %0d", i), "flags", d, VECS[i].exp_flag);
         read_reg(2'd2, d); check($sformatf("vector %0d", i), "missed", d, VECS[i].exp_miss);
      end
      write_reg(2'd2, 8'hFF);

      // R12 mask and irq
      write_reg(2'd1, 8'hFF);
      read_reg(2'd1, d); check("R12", "mask implemented bits", d, 8'h5F);
      write_reg(2'd1, 8'h01);
      check("R12", "irq with no flag", {7'b0, irq}, 8'h00);
      cc_evt = 4'h2; step();
      check("R12", "irq with unmasked-off flag", {7'b0, irq}, 8'h00);
      upd_evt = 1'b1; step();
      check("R12", "irq on enabled flag", {7'b0, irq}, 8'h01);
      write_reg(2'd1, 8'h00);
      check("R12", "irq after mask clear", {7'b0, irq}, 8'h00);
      write_reg(2'd0, 8'hFF);

      // R4 rising edge, normal mode, three-edge latency
      ext_trig = 1'b1;
      step(); read_reg(2'd0, d); check("R4", "trig edge 1", d, 8'h00);
      step(); read_reg(2'd0, d); check("R4", "trig edge 2", d, 8'h00);
      step(); read_reg(2'd0, d); check("R4", "trig edge 3", d, 8'h40);
      write_reg(2'd0, 8'h40);
      ext_trig = 1'b0;
      repeat (4) step();
      read_reg(2'd0, d); check("R4", "falling edge ignored", d, 8'h00);

      // R5 gated mode: either edge
      ext_trig = 1'b1;
      repeat (4) step();
      write_reg(2'd0, 8'h40);
      gated_mode = 1'b1;
      step();
      ext_trig = 1'b0;
      step(); step(); read_reg(2'd0, d); check("R5", "gated fall edge 2", d, 8'h00);
      step(); read_reg(2'd0, d); check("R5", "gated fall edge 3", d, 8'h40);
      gated_mode = 1'b0;

      // R1 reset mid-run clears everything
      write_reg(2'd1, 8'h40);
      cc_evt = 4'h1; step(); cc_evt = 4'h1; step();
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      read_reg(2'd0, d); check("R1", "flags after reset pulse", d, 8'h00);
      read_reg(2'd1, d); check("R1", "mask after reset pulse", d, 8'h00);
      read_reg(2'd2, d); check("R1", "missed after reset pulse", d, 8'h00);

      finish_run();
   end

endmodule